// File: doc/BRIEF.md
# Pulse and Quadrature Counter

This block counts steps derived from two sense inputs, `in_s0` and `in_s1`. A single input can be counted on its rising or falling edge, either oversampled with an optional stability filter or taken directly as an external clock. The two inputs can also be decoded as a quadrature pair, so that each legal Gray-code step moves the counter forward or back. The counter runs between zero and an active top value. Counting up wraps from top to zero. Counting down wraps from zero to top. Each wrap raises a one-cycle flag.

The top value is held in two registers. Software-side logic writes a staging register, and the active top changes only on a load-top command. A second command copies the active top into the counter. A clear input returns the counter and the auxiliary counter to zero and the active top to its default. The auxiliary counter increments on the step directions that its own event field selects. All configuration and command inputs are expected to be synchronous to `clk` already. Both sense inputs pass through one synchronizing flop before use.

Top module: `pulse_quad_counter`

## Requirements
- R1: After reset, `cnt_val` and `aux_val` are 0, `top_val` equals TOP_RST (default 255), and `ovf_evt`, `unf_evt` and `dir_down` are 0.
- R2: With `cfg_mode` = 0 (off), no input activity changes `cnt_val` or `aux_val`.
- R3: With `cfg_mode` = 1 (oversampled single) or 2 (direct single), one step is taken per edge of `in_s0`: the rising edge when `cfg_neg_edge` = 0, the falling edge when it is 1. The counter reflects an input change two clocks after the change is sampled (filter off).
- R4: In the single modes a step counts down when `cfg_s1_dir` = 0 and `cfg_down` = 1, or when `cfg_s1_dir` = 1 and the synchronized `in_s1` is high. Otherwise it counts up.
- R5: An up step with `cnt_val` >= `top_val` sets the counter to 0 and pulses `ovf_evt` for one cycle. Any other up step adds one.
- R6: A down step at `cnt_val` = 0 sets the counter to `top_val` (not the all-ones value) and pulses `unf_evt` for one cycle. Any other down step subtracts one.
- R7: `topb_wr` writes `topb_data` into the staging register only. `top_val` changes only on `cmd_load_top` (which takes the staging value present before that edge) or on clear.
- R8: `cmd_load_cnt` loads the active top value from before the edge into the counter. A step in the same cycle is dropped.
- R9: `clr_en` high for one cycle sets `cnt_val` and `aux_val` to 0 and `top_val` to TOP_RST. It overrides both commands and any step.
- R10: With `cfg_mode` = 3 the pair {s1,s0} counts up along 00,01,11,10,00 and down in the reverse order. `dir_down` shows the direction of the last step taken. A change of both bits at once is ignored.
- R11: With `cfg_mode` = 1 and `cfg_filt_en` = 1, a new input level is accepted only after FILT_LEN (default 3) consecutive differing samples, so shorter pulses are not counted.
- R12: `cfg_cnt_ev` selects the main counter's steps: 0 both, 1 up only, 2 down only, 3 none. `cfg_aux_ev` keeps 1 up and 2 down but uses 0 for none and 3 for both. The auxiliary counter adds one per selected step and wraps at its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 off, 1 oversampled single, 2 direct single, 3 quadrature |
| cfg_neg_edge | input | 1 | Count falling edges of s0 in single modes |
| cfg_down | input | 1 | Fixed down direction in single modes |
| cfg_filt_en | input | 1 | Enable the stability filter in mode 1 |
| cfg_s1_dir | input | 1 | Let s1 level choose direction in single modes |
| cfg_cnt_ev | input | 2 | Main counter step selection |
| cfg_aux_ev | input | 2 | Auxiliary counter step selection |
| clr_en | input | 1 | Clear counters and restore default top |
| topb_wr | input | 1 | Write staging top register |
| topb_data | input | CNT_W | Value for the staging top register |
| cmd_load_top | input | 1 | Copy staging top into active top |
| cmd_load_cnt | input | 1 | Copy active top into the counter |
| in_s0 | input | 1 | Sense input 0 |
| in_s1 | input | 1 | Sense input 1 |
| cnt_val | output | CNT_W | Main counter |
| aux_val | output | CNT_W | Auxiliary counter |
| top_val | output | CNT_W | Active top value |
| ovf_evt | output | 1 | One-cycle up-wrap flag |
| unf_evt | output | 1 | One-cycle down-wrap flag |
| dir_down | output | 1 | Direction of the last step |

## Verification
A wrong edge-detector or filter state shows up as a missing or extra step on `cnt_val` and `aux_val` within two clocks of the input change, or FILT_LEN+1 clocks with the filter on. A corrupted active top shows up directly on `top_val`. It also shows on the next wrap, either as a misplaced `ovf_evt` or as a wrong landing value after a down wrap. The reference model checks every output on every clock, so a divergence is reported in the cycle it first appears. Errors in the quadrature decoder show through `dir_down` as well as through the count.

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned FILT_LEN = 3,
  parameter logic [CNT_W-1:0] TOP_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_neg_edge,
  input  logic             cfg_down,
  input  logic             cfg_filt_en,
  input  logic             cfg_s1_dir,
  input  logic [1:0]       cfg_cnt_ev,
  input  logic [1:0]       cfg_aux_ev,
  input  logic             clr_en,
  input  logic             topb_wr,
  input  logic [CNT_W-1:0] topb_data,
  input  logic             cmd_load_top,
  input  logic             cmd_load_cnt,
  input  logic             in_s0,
  input  logic             in_s1,
  output logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] aux_val,
  output logic [CNT_W-1:0] top_val,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic             dir_down
);

  localparam int unsigned FW = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [1:0] M_OFF = 2'd0, M_OVS = 2'd1, M_QUAD = 2'd3;

  logic [1:0] s_d, s_a, s_p;
  logic [CNT_W-1:0] cnt_q, aux_q, top_q, topb_q;
  logic ovf_q, unf_q, dir_q;

  wire filt_on = cfg_filt_en && (cfg_mode == M_OVS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_d <= 2'b00;
      s_p <= 2'b00;
    end else begin
      s_d <= {in_s1, in_s0};
      s_p <= s_a;
    end

  for (genvar i = 0; i < 2; i++) begin : g_in
    logic [FW-1:0] run_q;
    logic          acc_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_q <= '0;
        acc_q <= 1'b0;
      end else if (!filt_on) begin
        run_q <= '0;
        acc_q <= s_d[i];
      end else if (s_d[i] == acc_q) begin
        run_q <= '0;
      end else if (run_q == FW'(FILT_LEN - 1)) begin
        run_q <= '0;
        acc_q <= s_d[i];
      end else begin
        run_q <= run_q + 1'b1;
      end
    assign s_a[i] = acc_q;
  end

  wire s0_edge = cfg_neg_edge ? (s_p[0] & ~s_a[0]) : (~s_p[0] & s_a[0]);
  wire q_legal = (s_a[0] ^ s_p[0]) != (s_a[1] ^ s_p[1]);
  wire q_fwd   = (s_a == {s_p[0], ~s_p[1]});

  logic step_v, step_dn;
  always_comb begin
    step_v  = 1'b0;
    step_dn = 1'b0;
    if (cfg_mode == M_QUAD) begin
      step_v  = q_legal;
      step_dn = ~q_fwd;
    end else if (cfg_mode != M_OFF) begin
      step_v  = s0_edge;
      step_dn = cfg_s1_dir ? s_a[1] : cfg_down;
    end
  end

  wire [1:0] aux_sel = (cfg_aux_ev == 2'd0) ? 2'd3 :
                       (cfg_aux_ev == 2'd3) ? 2'd0 : cfg_aux_ev;

  wire main_hit = step_v && ((cfg_cnt_ev == 2'd0) ||
                  (cfg_cnt_ev == 2'd1 && !step_dn) || (cfg_cnt_ev == 2'd2 && step_dn));
  wire aux_hit  = step_v && ((aux_sel == 2'd0) ||
                  (aux_sel == 2'd1 && !step_dn) || (aux_sel == 2'd2 && step_dn));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      aux_q  <= '0;
      top_q  <= TOP_RST;
      topb_q <= TOP_RST;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      if (topb_wr) topb_q <= topb_data;
      if (step_v) dir_q <= step_dn;
      if (clr_en) begin
        cnt_q <= '0;
        aux_q <= '0;
        top_q <= TOP_RST;
      end else begin
        if (cmd_load_top) top_q <= topb_q;
        if (cmd_load_cnt) begin
          cnt_q <= top_q;
        end else if (main_hit) begin
          if (!step_dn) begin
            if (cnt_q >= top_q) begin
              cnt_q <= '0;
              ovf_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_q <= top_q;
              unf_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
        if (aux_hit) aux_q <= aux_q + ONE;
      end
    end

  assign cnt_val  = cnt_q;
  assign aux_val  = aux_q;
  assign top_val  = top_q;
  assign ovf_evt  = ovf_q;
  assign unf_evt  = unf_q;
  assign dir_down = dir_q;

  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_OFF && !clr_en && !cmd_load_cnt) |=> $stable(cnt_val) && $stable(aux_val));
  p_no_both_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_evt && unf_evt));
  p_ovf_lands_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> cnt_val == '0);
  p_unf_lands_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |-> cnt_val == top_val);
  p_top_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_load_top || clr_en) |=> $stable(top_val));
  p_load_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load_cnt && !clr_en) |=> cnt_val == $past(top_val));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (cnt_val == '0 && aux_val == '0 && top_val == TOP_RST));

endmodule

// File: tb/pulse_quad_counter_tb_top.sv
module pulse_quad_counter_tb_top;
  localparam int FL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_cnt_ev = 2'd0, cfg_aux_ev = 2'd3;
  logic cfg_neg_edge = 0, cfg_down = 0, cfg_filt_en = 0, cfg_s1_dir = 0;
  logic clr_en = 0, topb_wr = 0, cmd_load_top = 0, cmd_load_cnt = 0;
  logic [7:0] topb_data = 8'd0;
  logic in_s0 = 0, in_s1 = 0;
  logic [7:0] cnt_val, aux_val, top_val;
  logic ovf_evt, unf_evt, dir_down;

  always #4 clk = ~clk;

  pulse_quad_counter #(.CNT_W(8), .FILT_LEN(FL), .TOP_RST(8'hFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_neg_edge(cfg_neg_edge),
    .cfg_down(cfg_down), .cfg_filt_en(cfg_filt_en), .cfg_s1_dir(cfg_s1_dir),
    .cfg_cnt_ev(cfg_cnt_ev), .cfg_aux_ev(cfg_aux_ev), .clr_en(clr_en),
    .topb_wr(topb_wr), .topb_data(topb_data), .cmd_load_top(cmd_load_top),
    .cmd_load_cnt(cmd_load_cnt), .in_s0(in_s0), .in_s1(in_s1),
    .cnt_val(cnt_val), .aux_val(aux_val), .top_val(top_val),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .dir_down(dir_down));

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  string phase = "R1";

  int m_d[2], m_a[2], m_p[2], m_f[2];
  int m_cnt, m_aux, m_top, m_topb;
  bit m_ovf, m_unf, m_dir;

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_d[i] = 0; m_a[i] = 0; m_p[i] = 0; m_f[i] = 0; end
    m_cnt = 0; m_aux = 0; m_top = 255; m_topb = 255;
    m_ovf = 0; m_unf = 0; m_dir = 0;
  endtask

  function automatic int gray_pos(int v);
    case (v)
      0: return 0;
      1: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic model_step();
    bit sv, sdn, mh, ah, filt;
    int old_top, old_topb, ev, d, raw[2];
    sv = 0; sdn = 0;
    raw[0] = in_s0; raw[1] = in_s1;
    if (cfg_mode == 1 || cfg_mode == 2) begin
      if (cfg_neg_edge ? (m_p[0] == 1 && m_a[0] == 0) : (m_p[0] == 0 && m_a[0] == 1)) begin
        sv = 1;
        sdn = cfg_s1_dir ? bit'(m_a[1]) : cfg_down;
      end
    end else if (cfg_mode == 3) begin
      d = (gray_pos(m_a[1]*2 + m_a[0]) - gray_pos(m_p[1]*2 + m_p[0]) + 4) % 4;
      if (d == 1) begin sv = 1; sdn = 0; end
      else if (d == 3) begin sv = 1; sdn = 1; end
    end
    ev = cfg_cnt_ev;
    mh = sv && (ev == 0 || (ev == 1 && !sdn) || (ev == 2 && sdn));
    ev = cfg_aux_ev;
    ah = sv && (ev == 3 || (ev == 1 && !sdn) || (ev == 2 && sdn));
    old_top = m_top; old_topb = m_topb;
    m_ovf = 0; m_unf = 0;
    if (topb_wr) m_topb = topb_data;
    if (sv) m_dir = sdn;
    if (clr_en) begin
      m_cnt = 0; m_aux = 0; m_top = 255;
    end else begin
      if (cmd_load_top) m_top = old_topb;
      if (cmd_load_cnt) m_cnt = old_top;
      else if (mh) begin
        if (!sdn) begin
          if (m_cnt >= old_top) begin m_cnt = 0; m_ovf = 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_cnt = old_top; m_unf = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (ah) m_aux = (m_aux + 1) % 256;
    end
    filt = (cfg_mode == 1) && cfg_filt_en;
    for (int i = 0; i < 2; i++) begin
      m_p[i] = m_a[i];
      if (!filt) begin m_a[i] = m_d[i]; m_f[i] = 0; end
      else if (m_d[i] == m_a[i]) m_f[i] = 0;
      else if (m_f[i] == FL - 1) begin m_a[i] = m_d[i]; m_f[i] = 0; end
      else m_f[i] = m_f[i] + 1;
      m_d[i] = raw[i];
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "cnt_val", int'(cnt_val), m_cnt);
      chk(phase, "aux_val", int'(aux_val), m_aux);
      chk(phase, "top_val", int'(top_val), m_top);
      chk(phase, "ovf_evt", int'(ovf_evt), int'(m_ovf));
      chk(phase, "unf_evt", int'(unf_evt), int'(m_unf));
      chk(phase, "dir_down", int'(dir_down), int'(m_dir));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_s0(int hi, int lo);
    in_s0 = 1; tick(hi);
    in_s0 = 0; tick(lo);
  endtask

  task automatic quad(int v);
    in_s1 = v[1]; in_s0 = v[0]; tick(3);
  endtask

  int aux_ref;

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1", "reset cnt", int'(cnt_val), 0);
    chk("R1", "reset top", int'(top_val), 255);
    chk("R1", "reset aux", int'(aux_val), 0);
    chk("R1", "reset flags", int'({ovf_evt, unf_evt, dir_down}), 0);

    phase = "R2";
    cfg_mode = 2'd0;
    for (int k = 0; k < 4; k++) pulse_s0(2, 2);
    chk("R2", "off cnt", int'(cnt_val), 0);

    phase = "R3";
    cfg_mode = 2'd2;
    for (int k = 0; k < 5; k++) pulse_s0(2, 2);
    tick(2);
    chk("R3", "rising cnt", int'(cnt_val), 5);
    cfg_neg_edge = 1;
    for (int k = 0; k < 3; k++) pulse_s0(2, 2);
    tick(2);
    chk("R3", "falling cnt", int'(cnt_val), 8);

    phase = "R4";
    cfg_neg_edge = 0; cfg_down = 1;
    for (int k = 0; k < 2; k++) pulse_s0(2, 2);
    tick(2);
    chk("R4", "down cnt", int'(cnt_val), 6);
    cfg_down = 0; cfg_s1_dir = 1; in_s1 = 1; tick(4);
    for (int k = 0; k < 3; k++) pulse_s0(2, 2);
    tick(2);
    chk("R4", "s1 dir cnt", int'(cnt_val), 3);
    in_s1 = 0; cfg_s1_dir = 0; tick(4);

    phase = "R5";
    topb_data = 8'd4; topb_wr = 1; tick(1); topb_wr = 0;
    cmd_load_top = 1; tick(1); cmd_load_top = 0; tick(1);
    chk("R5", "top loaded", int'(top_val), 4);
    for (int k = 0; k < 2; k++) pulse_s0(2, 2);
    tick(2);
    chk("R5", "up wrap cnt", int'(cnt_val), 0);

    phase = "R6";
    cfg_down = 1;
    pulse_s0(2, 3);
    chk("R6", "down wrap cnt", int'(cnt_val), 4);
    cfg_down = 0;

    phase = "R7";
    topb_data = 8'd9; topb_wr = 1; tick(1); topb_wr = 0; tick(5);
    chk("R7", "top held", int'(top_val), 4);
    cmd_load_top = 1; tick(1); cmd_load_top = 0; tick(1);
    chk("R7", "top after load", int'(top_val), 9);

    phase = "R8";
    cmd_load_cnt = 1; tick(1); cmd_load_cnt = 0; tick(1);
    chk("R8", "cnt from top", int'(cnt_val), 9);

    phase = "R9";
    clr_en = 1; cmd_load_cnt = 1; tick(1); clr_en = 0; cmd_load_cnt = 0; tick(1);
    chk("R9", "clr cnt", int'(cnt_val), 0);
    chk("R9", "clr top", int'(top_val), 255);
    chk("R9", "clr aux", int'(aux_val), 0);

    phase = "R10";
    cfg_mode = 2'd3; tick(3);
    quad(1); quad(3); quad(2); quad(0); tick(2);
    chk("R10", "fwd cnt", int'(cnt_val), 4);
    chk("R10", "fwd dir", int'(dir_down), 0);
    quad(2); quad(3); tick(2);
    chk("R10", "rev cnt", int'(cnt_val), 2);
    chk("R10", "rev dir", int'(dir_down), 1);
    quad(0); tick(2);
    chk("R10", "illegal cnt", int'(cnt_val), 2);
    chk("R10", "illegal dir", int'(dir_down), 1);
    quad(1); tick(2);
    chk("R10", "step after jump", int'(cnt_val), 3);
    quad(0); tick(2);

    phase = "R11";
    cfg_mode = 2'd1; cfg_filt_en = 1; tick(3);
    pulse_s0(2, 6);
    chk("R11", "glitch filtered", int'(cnt_val), 2);
    pulse_s0(4, 6);
    chk("R11", "long pulse", int'(cnt_val), 3);
    cfg_filt_en = 0; tick(2);
    pulse_s0(2, 4);
    chk("R11", "unfiltered glitch", int'(cnt_val), 4);

    phase = "R12";
    aux_ref = int'(aux_val);
    cfg_cnt_ev = 2'd1; cfg_aux_ev = 2'd0; cfg_down = 1;
    for (int k = 0; k < 2; k++) pulse_s0(2, 3);
    chk("R12", "up-only ignores down", int'(cnt_val), 4);
    chk("R12", "aux none", int'(aux_val), aux_ref);
    cfg_cnt_ev = 2'd2; cfg_aux_ev = 2'd2;
    for (int k = 0; k < 2; k++) pulse_s0(2, 3);
    chk("R12", "down-only cnt", int'(cnt_val), 2);
    chk("R12", "aux down", int'(aux_val), aux_ref + 2);
    cfg_cnt_ev = 2'd3; cfg_aux_ev = 2'd1;
    for (int k = 0; k < 2; k++) pulse_s0(2, 3);
    chk("R12", "none cnt", int'(cnt_val), 2);
    chk("R12", "aux up-only", int'(aux_val), aux_ref + 2);
    cfg_aux_ev = 2'd3;
    pulse_s0(2, 3);
    chk("R12", "aux both", int'(aux_val), aux_ref + 3);

    tick(3);
    finish_run();
  end
endmodule